// File: doc/BRIEF.md
# Serial EEPROM Page-Write Sequencer

This block writes a run of bytes into a two-wire serial EEPROM. A request gives a start byte address and a byte count. The bytes then arrive on a separate valid/ready stream. The block cuts the run into transactions that each stay inside one device page. It steers a bit-level bus engine through a small command channel. The command codes are start condition, stop condition and byte write. For every byte written, the engine returns the acknowledge bit.

Before every page transaction, and once more after the last one, the sequencer polls the device. A poll is a start condition followed by the device address byte. A refused poll is closed with a stop. The block then waits a fixed gap and polls again. An accepted poll goes straight on to the word address of the next page. After the final poll it closes with a stop and pulses `done`. Too many refused polls, or a refused word-address or data byte, end the request with a stop and an `err` pulse.

Back-pressure rules: `req_ready` is high only while the block is idle, and a request is taken on a cycle where `req_valid` and `req_ready` are both high. `s_ready` is high only during a data-byte phase, and only while the engine accepts the command (`cmd_ready`). A stream byte is therefore taken exactly when the engine takes it. `cmd_valid` never depends on `cmd_ready`. Once it is raised, `cmd_valid` and `cmd_op` hold until the engine accepts them. The stream source must hold `s_valid` and `s_data` until the byte is accepted.

Top module: `eepw_page_writer`

## Requirements
- R1: After reset the block is idle, with `req_ready`=1 and `cmd_valid`, `s_ready`, `done` and `err` all 0.
- R2: Every page transaction has this command order: start (`cmd_op`=0), then a write (`cmd_op`=2) of the device byte {4'b1010, address bits 10:8, 1'b0}, then a write of address bits 7:0, then the data bytes in stream order, then a stop (`cmd_op`=1). Each stream byte lands at start address plus its index, modulo the address space.
- R3: No transaction crosses a page boundary. The first holds min(length, PAGE − address mod PAGE) bytes. Each later one holds min(PAGE, bytes left).
- R4: Every transaction is preceded by a poll (start, then the device byte), and one more poll follows the last transaction. A refused poll is followed by a stop and then by at least GAP_CYC cycles before the next start is accepted.
- R5: If MAX_POLLS polls in a row are refused, the block issues a stop and pulses `err`, and no `done` follows.
- R6: A refused word-address or data byte causes a stop and an `err` pulse. No further stream bytes are taken.
- R7: `done` is a one-cycle pulse that comes after the stop that follows the accepted final poll. `done` and `err` are never high together.
- R8: A request of length 0 gives a `done` pulse in the next cycle and issues no bus command.
- R9: `s_ready` is high only during a data write that the engine is accepting. A pending command holds `cmd_valid` and `cmd_op` until it is accepted.
- R10: `req_ready` is 0 from the cycle after a nonzero request is accepted until the request ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Idle, request can be taken |
| req_addr | input | ADDR_W | First byte address |
| req_len | input | LEN_W | Number of bytes to write |
| s_valid | input | 1 | Stream byte offered |
| s_ready | output | 1 | Stream byte taken this cycle |
| s_data | input | 8 | Stream byte |
| cmd_valid | output | 1 | Command to bus engine pending |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_op | output | 2 | 0 start, 1 stop, 2 write byte |
| cmd_data | output | 8 | Byte for a write command |
| rsp_valid | input | 1 | Engine reports the acknowledge of a written byte |
| rsp_ack | input | 1 | 1 if the device acknowledged |
| done | output | 1 | One-cycle pulse, request finished |
| err | output | 1 | One-cycle pulse, request aborted |

## Verification
Wrong page arithmetic shows up as a wrong chunk count in the current transaction. A behavioural device model wraps inside the page, so in the same run the memory image shows overwritten bytes at the start of a page and missing bytes past the boundary. A wrong address counter or byte count shows up within one transaction: the device byte or word address is wrong, or the stop comes early or late. A broken poll or gap counter shows up at the next refused poll: the start comes too early, or there are too many or too few polls before the error pulse. A sweep of every page offset against lengths from one byte to more than two pages covers each chunk shape, both with and without back-pressure.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2
  } eepw_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL_START,
    ST_POLL_DEV,
    ST_POLL_RSP,
    ST_RETRY_STOP,
    ST_GAP,
    ST_WADDR,
    ST_WADDR_RSP,
    ST_DATA,
    ST_DATA_RSP,
    ST_PAGE_STOP,
    ST_FINAL_STOP,
    ST_ERR_STOP
  } eepw_state_e;
endpackage

// File: rtl/eepw_chunk.sv
module eepw_chunk #(
  parameter int LEN_W = 12,
  parameter int PAGE  = 16,
  localparam int PG_W = $clog2(PAGE),
  localparam int CH_W = PG_W + 1
) (
  input  logic [PG_W-1:0]  off_i,
  input  logic [LEN_W-1:0] rem_i,
  output logic [CH_W-1:0]  chunk_o
);
  logic [CH_W-1:0] room;

  always_comb begin
    room = CH_W'(PAGE) - {1'b0, off_i};
    if (rem_i < LEN_W'(room)) chunk_o = CH_W'(rem_i);
    else                      chunk_o = room;
  end
endmodule

// File: rtl/eepw_poll_retry.sv
module eepw_poll_retry #(
  parameter int MAX_POLLS = 8,
  parameter int GAP_CYC   = 4,
  localparam int CW = $clog2(MAX_POLLS + 1),
  localparam int GW = $clog2(GAP_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic nack_i,
  input  logic gap_ld_i,
  output logic last_o,
  output logic gap_end_o
);
  logic [CW-1:0] cnt;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) cnt <= '0;
    else if (nack_i)     cnt <= cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          gap <= '0;
    else if (gap_ld_i)   gap <= GW'(GAP_CYC);
    else if (gap != '0)  gap <= gap - GW'(1);
  end

  assign last_o    = (cnt == CW'(MAX_POLLS - 1));
  assign gap_end_o = (gap == GW'(1));

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(MAX_POLLS)); // R5
  AST_GAP_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    gap_ld_i |=> gap == GW'(GAP_CYC)); // R4
endmodule

// File: rtl/eepw_page_writer.sv
module eepw_page_writer
  import eepw_pkg::*;
#(
  parameter int   ADDR_W    = 11,
  parameter int   LEN_W     = 12,
  parameter int   PAGE      = 16,
  parameter int   MAX_POLLS = 8,
  parameter int   GAP_CYC   = 4,
  parameter logic [3:0] DEV_TYPE = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [7:0]        cmd_data,
  input  logic              rsp_valid,
  input  logic              rsp_ack,
  output logic              done,
  output logic              err
);
  localparam int PG_W = $clog2(PAGE);
  localparam int CH_W = PG_W + 1;

  eepw_state_e       state;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [CH_W-1:0]   chunk_q;
  logic [CH_W-1:0]   chunk_w;
  logic              done_q, err_q;
  logic [2:0]        blk;
  logic              last_poll, gap_end;
  logic              poll_ok, poll_bad;

  generate
    if (ADDR_W > 8) begin : g_blk
      assign blk = 3'(addr_q[ADDR_W-1:8]);
    end else begin : g_noblk
      assign blk = 3'd0;
    end
  endgenerate

  eepw_chunk #(.LEN_W(LEN_W), .PAGE(PAGE)) u_chunk (
    .off_i  (addr_q[PG_W-1:0]),
    .rem_i  (rem_q),
    .chunk_o(chunk_w)
  );

  assign poll_ok  = (state == ST_POLL_RSP) && rsp_valid && rsp_ack;
  assign poll_bad = (state == ST_POLL_RSP) && rsp_valid && !rsp_ack;

  eepw_poll_retry #(.MAX_POLLS(MAX_POLLS), .GAP_CYC(GAP_CYC)) u_retry (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    ((state == ST_IDLE) || poll_ok),
    .nack_i   (poll_bad && !last_poll),
    .gap_ld_i ((state == ST_RETRY_STOP) && cmd_ready),
    .last_o   (last_poll),
    .gap_end_o(gap_end)
  );

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_WRITE;
    cmd_data  = 8'h00;
    unique case (state)
      ST_POLL_START: begin cmd_valid = 1'b1; cmd_op = OP_START; end
      ST_POLL_DEV:   begin cmd_valid = 1'b1; cmd_data = {DEV_TYPE, blk, 1'b0}; end
      ST_WADDR:      begin cmd_valid = 1'b1; cmd_data = addr_q[7:0]; end
      ST_DATA:       begin cmd_valid = s_valid; cmd_data = s_data; end
      ST_RETRY_STOP, ST_PAGE_STOP, ST_FINAL_STOP, ST_ERR_STOP:
                     begin cmd_valid = 1'b1; cmd_op = OP_STOP; end
      default: ;
    endcase
  end

  assign req_ready = (state == ST_IDLE);
  assign s_ready   = (state == ST_DATA) && cmd_ready;
  assign done      = done_q;
  assign err       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      chunk_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          rem_q  <= req_len;
          if (req_len == '0) done_q <= 1'b1;
          else               state  <= ST_POLL_START;
        end
        ST_POLL_START: if (cmd_ready) state <= ST_POLL_DEV;
        ST_POLL_DEV:   if (cmd_ready) state <= ST_POLL_RSP;
        ST_POLL_RSP: if (rsp_valid) begin
          if (rsp_ack) begin
            if (rem_q == '0) state <= ST_FINAL_STOP;
            else begin
              chunk_q <= chunk_w;
              state   <= ST_WADDR;
            end
          end else if (last_poll) state <= ST_ERR_STOP;
          else                    state <= ST_RETRY_STOP;
        end
        ST_RETRY_STOP: if (cmd_ready) state <= ST_GAP;
        ST_GAP:        if (gap_end) state <= ST_POLL_START;
        ST_WADDR:      if (cmd_ready) state <= ST_WADDR_RSP;
        ST_WADDR_RSP: if (rsp_valid) state <= rsp_ack ? ST_DATA : ST_ERR_STOP;
        ST_DATA: if (s_valid && cmd_ready) begin
          addr_q  <= addr_q + ADDR_W'(1);
          rem_q   <= rem_q - LEN_W'(1);
          chunk_q <= chunk_q - CH_W'(1);
          state   <= ST_DATA_RSP;
        end
        ST_DATA_RSP: if (rsp_valid) begin
          if (!rsp_ack)            state <= ST_ERR_STOP;
          else if (chunk_q == '0)  state <= ST_PAGE_STOP;
          else                     state <= ST_DATA;
        end
        ST_PAGE_STOP: if (cmd_ready) state <= ST_POLL_START;
        ST_FINAL_STOP: if (cmd_ready) begin
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        ST_ERR_STOP: if (cmd_ready) begin
          err_q <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op))); // R9
  AST_STREAM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (cmd_op == OP_WRITE && !req_ready)); // R9
  AST_CHUNK_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WADDR) |-> (chunk_q != '0 &&
      ({1'b0, addr_q[PG_W-1:0]} + chunk_q) <= CH_W'(PAGE))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err); // R6
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R7
endmodule

// File: tb/eepw_page_writer_test.sv
`timescale 1ns/1ps
module eepw_page_writer_test;
  localparam int ADDR_W = 11, LEN_W = 12, PG = 8, MAXP = 5, GAP = 3;
  localparam int MSZ = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic s_valid = 1'b0, s_ready;
  logic [7:0] s_data = 8'h00;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;
  logic rsp_valid = 1'b0, rsp_ack = 1'b0;
  logic done, err;

  eepw_page_writer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE(PG),
    .MAX_POLLS(MAXP), .GAP_CYC(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
    .done(done), .err(err));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0, run_id = 0;
  int n_cmd, n_poll, data_idx, s_idx, done_cnt, err_cnt;
  int busy, busy_cfg, nack_data_at, nack_wa, bp, cur_len, feed_en;
  int in_tx, bidx, wrote, ntx, stop_cyc, stop_nack, last_op, nack_seen;
  int tx_size [64];
  int pend = 0, pend_ack = 0, s_taken = 0;
  logic [2:0] blk;
  logic [7:0] wa;
  logic [7:0] mem [MSZ];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int r, input int i);
    return 8'((i * 13 + r * 7) | 128);
  endfunction

  // device and bus-engine model
  always @(negedge clk) begin
    if (!rst_n) begin
      rsp_valid = 1'b0; cmd_ready = 1'b0; s_valid = 1'b0; pend = 0;
    end else begin
      cyc++;
      rsp_valid = pend[0]; rsp_ack = pend_ack[0]; pend = 0;
      cmd_ready = (bp != 0) ? (cyc % 3 != 2) : 1'b1;
      if (s_taken != 0 || feed_en == 0) s_valid = 1'b0;
      s_taken = 0;
      if (!s_valid)
        s_valid = (feed_en != 0) && (s_idx < cur_len) && ((bp == 0) || (cyc % 4 != 1));
      s_data = pat(run_id, s_idx);
      #1;
      if (s_valid && s_ready) begin s_idx++; s_taken = 1; end
      if (cmd_valid && cmd_ready) begin
        n_cmd++;
        last_op = cmd_op;
        case (cmd_op)
          2'd0: begin
            if (stop_nack != 0)
              chk(cyc - stop_cyc >= GAP + 1, "R4", "gap before retry", cyc - stop_cyc, GAP + 1);
            stop_nack = 0; in_tx = 1; bidx = 0; wrote = 0; nack_seen = 0;
          end
          2'd1: begin
            if (in_tx != 0 && wrote > 0) begin
              if (ntx < 64) tx_size[ntx] = wrote;
              ntx++;
              busy = busy_cfg;
            end
            stop_nack = nack_seen; stop_cyc = cyc; in_tx = 0;
          end
          default: begin
            if (in_tx == 0) chk(1'b0, "R2", "write outside transaction", 0, 1);
            pend = 1; pend_ack = 1;
            if (bidx == 0) begin
              n_poll++;
              if (cmd_data[7:4] != 4'hA || cmd_data[0] != 1'b0)
                chk(1'b0, "R2", "device byte", cmd_data, 8'hA0);
              if (busy > 0) begin busy--; pend_ack = 0; nack_seen = 1; end
              else blk = cmd_data[3:1];
            end else if (bidx == 1) begin
              wa = cmd_data;
              if (nack_wa != 0) pend_ack = 0;
            end else begin
              mem[{blk, wa}] = cmd_data;
              wa = {wa[7:3], wa[2:0] + 3'd1};
              wrote++;
              if (data_idx == nack_data_at) pend_ack = 0;
              data_idx++;
            end
            bidx++;
          end
        endcase
      end
      if (done) begin
        done_cnt++;
        if (cur_len != 0) chk(last_op == 1, "R7", "done after stop", last_op, 1);
      end
      if (err) err_cnt++;
      chk(!(done && err), "R7", "done and err together", done, 0);
    end
  end

  task automatic do_run(input int addr, input int len, input int bcfg, input int bpm,
                        input int nd, input int nw);
    @(negedge clk); #2;
    run_id++;
    for (int i = 0; i < MSZ; i++) mem[i] = 8'h5A;
    n_cmd = 0; n_poll = 0; data_idx = 0; s_idx = 0; done_cnt = 0; err_cnt = 0;
    busy = 0; busy_cfg = bcfg; bp = bpm; nack_data_at = nd; nack_wa = nw;
    ntx = 0; in_tx = 0; stop_nack = 0; cur_len = len; feed_en = 1; last_op = -1;
    req_addr = ADDR_W'(addr); req_len = LEN_W'(len); req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk); #2;
    req_valid = 1'b0;
    if (len != 0) chk(req_ready == 1'b0, "R10", "req_ready while busy", req_ready, 0);
    for (int t = 0; t < 4000 && done_cnt + err_cnt == 0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    #2 feed_en = 0;
  endtask

  task automatic check_ok(input int addr, input int len, input int bcfg);
    int off, nexp, left, sz, bad;
    off = addr % PG;
    nexp = (off + len + PG - 1) / PG;
    chk(done_cnt == 1 && err_cnt == 0, "R7", "done pulse count", done_cnt, 1);
    chk(ntx == nexp, "R3", "transaction count", ntx, nexp);
    bad = 0; left = len;
    for (int k = 0; k < nexp && k < 64 && k < ntx; k++) begin
      sz = (k == 0) ? PG - off : PG;
      if (sz > left) sz = left;
      if (tx_size[k] != sz) bad++;
      left -= sz;
    end
    chk(bad == 0, "R3", "chunk sizes wrong", bad, 0);
    bad = 0;
    for (int i = 0; i < len; i++)
      if (mem[(addr + i) % MSZ] != pat(run_id, i)) bad++;
    if (len < MSZ - 2) begin
      if (mem[(addr + MSZ - 1) % MSZ] != 8'h5A) bad++;
      if (mem[(addr + len) % MSZ] != 8'h5A) bad++;
    end
    chk(bad == 0, "R2", "memory image mismatches", bad, 0);
    chk(s_idx == len, "R2", "stream bytes taken", s_idx, len);
    chk(n_poll == nexp + 1 + nexp * bcfg, "R4", "poll count", n_poll, nexp + 1 + nexp * bcfg);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #2;
    chk(req_ready == 1'b1, "R1", "req_ready at reset", req_ready, 1);
    chk(cmd_valid == 1'b0 && s_ready == 1'b0, "R1", "cmd_valid/s_ready at reset", cmd_valid, 0);
    chk(done == 1'b0 && err == 1'b0, "R1", "done/err at reset", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    chk(req_ready == 1'b1 && cmd_valid == 1'b0, "R1", "idle after reset", req_ready, 1);

    // R2 R3 R4 R7: sweep of page offsets against lengths
    for (int off = 0; off < PG; off++)
      for (int len = 1; len <= 20; len++) begin
        int a;
        a = ((off * 20 + len) * 37 % 256) * PG + off;
        do_run(a, len, (off + len) % 3, (off + len) % 2, -1, 0);
        check_ok(a, len, (off + len) % 3);
      end

    // R2: run across the top of the address space
    do_run(MSZ - 2, 10, 1, 1, -1, 0);
    check_ok(MSZ - 2, 10, 1);

    // R8: zero-length request
    do_run(100, 0, 0, 0, -1, 0);
    chk(done_cnt == 1 && err_cnt == 0, "R8", "zero-length done", done_cnt, 1);
    chk(n_cmd == 0, "R8", "zero-length bus commands", n_cmd, 0);

    // R5: device never answers the poll
    do_run(16, 4, 0, 0, -1, 0);
    busy = 0;
    do_run(16, 4, 0, 0, -1, 0);
    check_ok(16, 4, 0);
    busy_cfg = 0;
    @(negedge clk); #2;
    run_id++;
    n_cmd = 0; n_poll = 0; data_idx = 0; s_idx = 0; done_cnt = 0; err_cnt = 0;
    busy = 1000; busy_cfg = 0; bp = 0; nack_data_at = -1; nack_wa = 0; ntx = 0;
    stop_nack = 0; cur_len = 4; feed_en = 1;
    req_addr = ADDR_W'(24); req_len = LEN_W'(4); req_valid = 1'b1;
    @(posedge clk); @(negedge clk); #2 req_valid = 1'b0;
    for (int t = 0; t < 4000 && done_cnt + err_cnt == 0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    #2 feed_en = 0;
    chk(err_cnt == 1 && done_cnt == 0, "R5", "err after poll limit", err_cnt, 1);
    chk(n_poll == MAXP, "R5", "polls before error", n_poll, MAXP);
    chk(last_op == 1, "R5", "stop before error", last_op, 1);
    chk(s_idx == 0, "R5", "no stream taken", s_idx, 0);
    busy = 0;

    // R6: data byte refused at the start of the second page
    do_run(5, 10, 0, 0, 3, 0);
    chk(err_cnt == 1 && done_cnt == 0, "R6", "err on data refusal", err_cnt, 1);
    chk(s_idx == 4, "R6", "stream bytes taken", s_idx, 4);
    chk(last_op == 1, "R6", "stop after data refusal", last_op, 1);

    // R6: word address refused
    do_run(40, 6, 0, 1, -1, 1);
    chk(err_cnt == 1 && done_cnt == 0, "R6", "err on word address refusal", err_cnt, 1);
    chk(s_idx == 0, "R6", "no stream taken", s_idx, 0);
    chk(req_ready == 1'b1, "R10", "idle after error", req_ready, 1);

    // recovery after errors
    do_run(200, 12, 2, 1, -1, 0);
    check_ok(200, 12, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule